// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block sits behind a single host command port. Each 16-bit word the host writes carries an operation code and an argument. The unit decodes the word and updates a small set of registers: the selected register window, an interrupt enable mask, a mask of the status bits that reads may see, and the receiver and transmitter enable levels. It also emits one-cycle strobes toward the reset logic of the datapaths.

Event pulses from the transmit, receive, statistics and failure logic are latched as sticky status bits. These bits stay set until the host clears them with an acknowledge command whose argument selects the bits to clear. Reading or writing the status word never clears them. The unit combines the latched bits with the enable mask to drive an interrupt request line.

A global reset command returns every register to its power-up value. It then holds a busy flag for one millisecond's worth of clock cycles, and the unit ignores further commands while that flag is set. The status word packs the window number, the busy flag and the visible event bits. The word is captured on a read strobe.

Top module: `cmd_status_unit`

## Requirements
- R1: A command word is split into an opcode in bits 15..11 and an argument in bits 10..0. Opcodes other than 0, 1, 3, 4, 5, 9, 10, 11, 12, 13, 14 and 15 change no output and no state.
- R2: Opcode 1 loads the window from argument bits 2..0. The window appears on `window_o` and in status bits 15..13 from the cycle after the write.
- R3: Event pulses set sticky status bits in this map: bit 1 failure, bit 2 transmit done, bit 3 transmit space available, bit 4 receive done, bit 5 receive early, bit 7 statistics. A set bit stays set until it is acknowledged.
- R4: Opcode 13 clears every latched status bit (bits 7..0) whose matching argument bit 7..0 is 1.
- R5: Opcode 12 sets status bit 6.
- R6: Status bit 0 is set when any of bits 7..1 latches while its interrupt-enable bit is 1.
- R7: Opcode 14 loads the interrupt-enable mask from argument bits 7..0. `irq_o` is high exactly when some latched bit has its enable bit set.
- R8: Opcode 15 loads the read mask from argument bits 7..0. Status bits 7..0 show the latched bits ANDed with this mask, and status bits 11..8 read 0. The read mask resets to 0xFF and the enable mask resets to 0.
- R9: Opcode 0 resets the window, masks, latched bits and enables to their power-up values. Status bit 12 then reads 1 for exactly CLK_KHZ cycles, and commands written during that time are ignored.
- R10: Opcodes 4 and 3 set and clear `rx_en_o`. Opcodes 9 and 10 set and clear `tx_en_o`. Both are 0 after reset.
- R11: Opcodes 5, 11 and 0 each raise `rx_rst_o`, `tx_rst_o` or `gbl_rst_o` respectively, for the single cycle after the write.
- R12: When an event pulse and an acknowledge of the same bit arrive in one cycle, the bit ends up set.
- R13: With `stat_rd_i` high at a clock edge, `status_o` shows the status from before that edge. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_word_i | input | 16 | Command word: opcode and argument |
| stat_rd_i | input | 1 | Status read strobe |
| ev_fail_i | input | 1 | Failure event pulse |
| ev_tx_done_i | input | 1 | Transmit done event pulse |
| ev_tx_avail_i | input | 1 | Transmit space available pulse |
| ev_rx_done_i | input | 1 | Receive done event pulse |
| ev_rx_early_i | input | 1 | Receive early event pulse |
| ev_stats_i | input | 1 | Statistics update event pulse |
| status_o | output | 16 | Captured status word |
| window_o | output | 3 | Current register window |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enable level |
| tx_en_o | output | 1 | Transmitter enable level |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| gbl_rst_o | output | 1 | Global reset strobe |

## Verification
Every register, strobe and latched bit changes at the clock edge that samples the command or event, so its effect is due one cycle later. `irq_o` follows the latched bits with no further delay. A status value needs one edge with the read strobe high, so it reflects the state from before that edge. The bench drives inputs and compares outputs on the falling edge, and its reference model advances on each rising edge. Directed checks are placed at the falling edge after the edge that carries the stimulus. The busy window is measured by reading on every cycle and counting how many captures show bit 12 set.

// File: rtl/csu_pkg.sv
`timescale 1ns/1ps
package csu_pkg;

   typedef enum logic [4:0] {
      OP_GRST   = 5'd0,
      OP_WINSEL = 5'd1,
      OP_RXOFF  = 5'd3,
      OP_RXON   = 5'd4,
      OP_RXRST  = 5'd5,
      OP_TXON   = 5'd9,
      OP_TXOFF  = 5'd10,
      OP_TXRST  = 5'd11,
      OP_SWREQ  = 5'd12,
      OP_ACK    = 5'd13,
      OP_IMASK  = 5'd14,
      OP_RMASK  = 5'd15
   } csu_op_e;

   typedef struct packed {
      logic grst;
      logic winsel;
      logic rx_off;
      logic rx_on;
      logic rx_rst;
      logic tx_on;
      logic tx_off;
      logic tx_rst;
      logic sw_req;
      logic ack;
      logic ld_imask;
      logic ld_rmask;
   } csu_dec_t;

   // status event bit positions (software decodes these)
   localparam int EB_SUMMARY = 0;
   localparam int EB_FAIL    = 1;
   localparam int EB_TXDONE  = 2;
   localparam int EB_TXAVAIL = 3;
   localparam int EB_RXDONE  = 4;
   localparam int EB_RXEARLY = 5;
   localparam int EB_SWREQ   = 6;
   localparam int EB_STATS   = 7;

endpackage

// File: rtl/csu_cmd_decode.sv
`timescale 1ns/1ps
module csu_cmd_decode
   import csu_pkg::*;
#(
   parameter int CMD_W = 16,
   parameter int OPC_W = 5,
   localparam int ARG_W = CMD_W - OPC_W
) (
   input  logic             wr_i,
   input  logic [CMD_W-1:0] word_i,
   input  logic             busy_i,
   output csu_dec_t         dec_o,
   output logic [ARG_W-1:0] arg_o
);

   logic [OPC_W-1:0] opc;
   logic             take;

   assign opc   = word_i[CMD_W-1 -: OPC_W];
   assign arg_o = word_i[ARG_W-1:0];
   assign take  = wr_i & ~busy_i;

   always_comb begin
      dec_o = '0;
      if (take) begin
         case (csu_op_e'(opc))
            OP_GRST:   dec_o.grst     = 1'b1;
            OP_WINSEL: dec_o.winsel   = 1'b1;
            OP_RXOFF:  dec_o.rx_off   = 1'b1;
            OP_RXON:   dec_o.rx_on    = 1'b1;
            OP_RXRST:  dec_o.rx_rst   = 1'b1;
            OP_TXON:   dec_o.tx_on    = 1'b1;
            OP_TXOFF:  dec_o.tx_off   = 1'b1;
            OP_TXRST:  dec_o.tx_rst   = 1'b1;
            OP_SWREQ:  dec_o.sw_req   = 1'b1;
            OP_ACK:    dec_o.ack      = 1'b1;
            OP_IMASK:  dec_o.ld_imask = 1'b1;
            OP_RMASK:  dec_o.ld_rmask = 1'b1;
            default:   dec_o          = '0;
         endcase
      end
   end

endmodule

// File: rtl/csu_busy_timer.sv
`timescale 1ns/1ps
module csu_busy_timer #(
   parameter int HOLD_CYC = 250000,
   localparam int CNT_W = $clog2(HOLD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CNT_W'(HOLD_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/csu_event_latch.sv
`timescale 1ns/1ps
module csu_event_latch #(
   parameter int EVT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [EVT_W-1:1] raw_set_i,
   input  logic [EVT_W-1:0] ack_i,
   input  logic [EVT_W-1:0] imask_i,
   output logic [EVT_W-1:0] lat_o
);

   logic summary_set;
   logic summary_q;
   logic imask_lsb_unused;

   assign summary_set      = |(raw_set_i & imask_i[EVT_W-1:1]);
   assign imask_lsb_unused = imask_i[0];

   // one sticky flop per event source; a set beats an acknowledge
   for (genvar b = 1; b < EVT_W; b++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= 1'b0;
         end else if (flush_i) begin
            q <= 1'b0;
         end else if (raw_set_i[b]) begin
            q <= 1'b1;
         end else if (ack_i[b]) begin
            q <= 1'b0;
         end
      end
      assign lat_o[b] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         summary_q <= 1'b0;
      end else if (flush_i) begin
         summary_q <= 1'b0;
      end else if (summary_set) begin
         summary_q <= 1'b1;
      end else if (ack_i[0]) begin
         summary_q <= 1'b0;
      end
   end

   assign lat_o[0] = summary_q;

endmodule

// File: rtl/cmd_status_unit.sv
`timescale 1ns/1ps
module cmd_status_unit
   import csu_pkg::*;
#(
   parameter int CMD_W      = 16,
   parameter int OPC_W      = 5,
   parameter int WIN_W      = 3,
   parameter int EVT_W      = 8,
   parameter int CLK_KHZ    = 250000,
   parameter bit RD_CAPTURE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr_i,
   input  logic [CMD_W-1:0] cmd_word_i,
   input  logic             stat_rd_i,
   input  logic             ev_fail_i,
   input  logic             ev_tx_done_i,
   input  logic             ev_tx_avail_i,
   input  logic             ev_rx_done_i,
   input  logic             ev_rx_early_i,
   input  logic             ev_stats_i,
   output logic [CMD_W-1:0] status_o,
   output logic [WIN_W-1:0] window_o,
   output logic             irq_o,
   output logic             rx_en_o,
   output logic             tx_en_o,
   output logic             rx_rst_o,
   output logic             tx_rst_o,
   output logic             gbl_rst_o
);

   localparam int ARG_W    = CMD_W - OPC_W;
   localparam int HOLD_CYC = CLK_KHZ;
   localparam int PAD_W    = CMD_W - WIN_W - 1 - EVT_W;

   // elaboration-time parameter checks
   if (OPC_W != 5) begin : g_bad_opc
      $error("cmd_status_unit: OPC_W must be 5");
   end
   if (EVT_W != 8) begin : g_bad_evt
      $error("cmd_status_unit: EVT_W must be 8");
   end
   if (ARG_W < EVT_W || ARG_W < WIN_W) begin : g_bad_arg
      $error("cmd_status_unit: argument too narrow for masks or window");
   end
   if (PAD_W < 1) begin : g_bad_pad
      $error("cmd_status_unit: status word too narrow");
   end
   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("cmd_status_unit: CLK_KHZ must be positive");
   end

   csu_dec_t         dec;
   logic [ARG_W-1:0] arg;
   logic             busy;
   logic [EVT_W-1:1] raw_set;
   logic [EVT_W-1:0] ack_vec;
   logic [EVT_W-1:0] lat;
   logic [WIN_W-1:0] window_q;
   logic [EVT_W-1:0] imask_q;
   logic [EVT_W-1:0] rmask_q;
   logic             rx_en_q;
   logic             tx_en_q;
   logic             rx_rst_q;
   logic             tx_rst_q;
   logic             gbl_rst_q;
   logic [CMD_W-1:0] live_stat;
   logic             arg_hi_unused;

   assign arg_hi_unused = ^arg[ARG_W-1:EVT_W];

   csu_cmd_decode #(
      .CMD_W (CMD_W),
      .OPC_W (OPC_W)
   ) u_dec (
      .wr_i   (cmd_wr_i),
      .word_i (cmd_word_i),
      .busy_i (busy),
      .dec_o  (dec),
      .arg_o  (arg)
   );

   csu_busy_timer #(
      .HOLD_CYC (HOLD_CYC)
   ) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (dec.grst),
      .busy_o (busy)
   );

   assign raw_set[EB_FAIL]    = ev_fail_i;
   assign raw_set[EB_TXDONE]  = ev_tx_done_i;
   assign raw_set[EB_TXAVAIL] = ev_tx_avail_i;
   assign raw_set[EB_RXDONE]  = ev_rx_done_i;
   assign raw_set[EB_RXEARLY] = ev_rx_early_i;
   assign raw_set[EB_SWREQ]   = dec.sw_req;
   assign raw_set[EB_STATS]   = ev_stats_i;

   assign ack_vec = dec.ack ? arg[EVT_W-1:0] : '0;

   csu_event_latch #(
      .EVT_W (EVT_W)
   ) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (dec.grst),
      .raw_set_i (raw_set),
      .ack_i     (ack_vec),
      .imask_i   (imask_q),
      .lat_o     (lat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         window_q  <= '0;
         imask_q   <= '0;
         rmask_q   <= '1;
         rx_en_q   <= 1'b0;
         tx_en_q   <= 1'b0;
         rx_rst_q  <= 1'b0;
         tx_rst_q  <= 1'b0;
         gbl_rst_q <= 1'b0;
      end else begin
         rx_rst_q  <= dec.rx_rst;
         tx_rst_q  <= dec.tx_rst;
         gbl_rst_q <= dec.grst;
         if (dec.grst) begin
            window_q <= '0;
            imask_q  <= '0;
            rmask_q  <= '1;
            rx_en_q  <= 1'b0;
            tx_en_q  <= 1'b0;
         end else begin
            if (dec.winsel)   window_q <= arg[WIN_W-1:0];
            if (dec.ld_imask) imask_q  <= arg[EVT_W-1:0];
            if (dec.ld_rmask) rmask_q  <= arg[EVT_W-1:0];
            if (dec.rx_on)    rx_en_q  <= 1'b1;
            if (dec.rx_off)   rx_en_q  <= 1'b0;
            if (dec.tx_on)    tx_en_q  <= 1'b1;
            if (dec.tx_off)   tx_en_q  <= 1'b0;
         end
      end
   end

   assign live_stat = {window_q, busy, {PAD_W{1'b0}}, lat & rmask_q};

   if (RD_CAPTURE) begin : g_cap
      logic [CMD_W-1:0] stat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stat_q <= '0;
         end else if (stat_rd_i) begin
            stat_q <= live_stat;
         end
      end
      assign status_o = stat_q;
   end else begin : g_live
      logic rd_unused;
      assign rd_unused = stat_rd_i;
      assign status_o  = live_stat;
   end

   assign window_o  = window_q;
   assign irq_o     = |(lat & imask_q);
   assign rx_en_o   = rx_en_q;
   assign tx_en_o   = tx_en_q;
   assign rx_rst_o  = rx_rst_q;
   assign tx_rst_o  = tx_rst_q;
   assign gbl_rst_o = gbl_rst_q;

endmodule

// File: rtl/csu_chk.sv
`timescale 1ns/1ps
module csu_chk #(
   parameter int WIN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr,
   input logic [4:0]       opc,
   input logic [7:0]       arg8,
   input logic             busy,
   input logic             lat_rx,
   input logic             ev_any,
   input logic             ev_rx,
   input logic [WIN_W-1:0] window_o,
   input logic             irq_o,
   input logic             rx_en_o,
   input logic             tx_en_o,
   input logic             rx_rst_o,
   input logic             tx_rst_o,
   input logic             gbl_rst_o
);

   logic acc;
   assign acc = wr & ~busy;

   // R2
   win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc == 5'd1) |=> (window_o == $past(arg8[WIN_W-1:0])));

   // R7
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc == 5'd13 && arg8 == 8'hFF && !ev_any) |=> !irq_o);

   // R9
   grst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gbl_rst_o |-> busy);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && busy && opc == 5'd1) |=> $stable(window_o));

   // R10
   rx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc == 5'd4) |=> rx_en_o);

   // R10
   tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && opc == 5'd10) |=> !tx_en_o);

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_rst_o, tx_rst_o, gbl_rst_o}));

   // R11
   rx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst_o |-> $past(acc && opc == 5'd5));

   // R12
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx && !(acc && opc == 5'd0)) |=> lat_rx);

endmodule

bind cmd_status_unit csu_chk #(.WIN_W(WIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr        (cmd_wr_i),
   .opc       (cmd_word_i[CMD_W-1 -: 5]),
   .arg8      (cmd_word_i[7:0]),
   .busy      (busy),
   .lat_rx    (lat[4]),
   .ev_any    (ev_fail_i | ev_tx_done_i | ev_tx_avail_i | ev_rx_done_i | ev_rx_early_i | ev_stats_i),
   .ev_rx     (ev_rx_done_i),
   .window_o  (window_o),
   .irq_o     (irq_o),
   .rx_en_o   (rx_en_o),
   .tx_en_o   (tx_en_o),
   .rx_rst_o  (rx_rst_o),
   .tx_rst_o  (tx_rst_o),
   .gbl_rst_o (gbl_rst_o)
);

// File: tb/cmd_status_unit_tb_top.sv
`timescale 1ns/1ps
module cmd_status_unit_tb_top;

   localparam int HOLD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr_i = 1'b0;
   logic [15:0] cmd_word_i = '0;
   logic        stat_rd_i = 1'b0;
   logic        ev_fail_i = 1'b0, ev_tx_done_i = 1'b0, ev_tx_avail_i = 1'b0;
   logic        ev_rx_done_i = 1'b0, ev_rx_early_i = 1'b0, ev_stats_i = 1'b0;
   logic [15:0] status_o;
   logic [2:0]  window_o;
   logic        irq_o, rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, gbl_rst_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cmd_status_unit #(.CLK_KHZ(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_word_i(cmd_word_i),
      .stat_rd_i(stat_rd_i), .ev_fail_i(ev_fail_i), .ev_tx_done_i(ev_tx_done_i),
      .ev_tx_avail_i(ev_tx_avail_i), .ev_rx_done_i(ev_rx_done_i),
      .ev_rx_early_i(ev_rx_early_i), .ev_stats_i(ev_stats_i),
      .status_o(status_o), .window_o(window_o), .irq_o(irq_o),
      .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_rst_o(rx_rst_o),
      .tx_rst_o(tx_rst_o), .gbl_rst_o(gbl_rst_o)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [2:0]  m_win;
   bit [7:0]  m_lat, m_im, m_rm, m_set, m_clr;
   bit        m_rx, m_tx, m_rxs, m_txs, m_gs, m_acc;
   bit [15:0] m_stat;
   int        m_cnt, m_op;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_win = 0; m_lat = 0; m_im = 0; m_rm = 8'hFF; m_rx = 0; m_tx = 0;
         m_rxs = 0; m_txs = 0; m_gs = 0; m_stat = 0; m_cnt = 0;
      end else begin
         if (stat_rd_i) m_stat = {m_win, (m_cnt != 0), 4'b0000, m_lat & m_rm};
         m_op  = int'(cmd_word_i[15:11]);
         m_acc = cmd_wr_i && (m_cnt == 0);
         m_rxs = m_acc && m_op == 5;
         m_txs = m_acc && m_op == 11;
         m_gs  = m_acc && m_op == 0;
         if (m_cnt > 0) m_cnt--;
         if (m_gs) begin
            m_win = 0; m_lat = 0; m_im = 0; m_rm = 8'hFF; m_rx = 0; m_tx = 0;
            m_cnt = HOLD;
         end else begin
            m_set = {ev_stats_i, m_acc && m_op == 12, ev_rx_early_i, ev_rx_done_i,
                     ev_tx_avail_i, ev_tx_done_i, ev_fail_i, 1'b0};
            if ((m_set & m_im) != 0) m_set[0] = 1'b1;
            m_clr = (m_acc && m_op == 13) ? cmd_word_i[7:0] : 8'h00;
            m_lat = (m_lat & ~m_clr) | m_set;
            if (m_acc) begin
               case (m_op)
                  1:  m_win = cmd_word_i[2:0];
                  3:  m_rx = 0;
                  4:  m_rx = 1;
                  9:  m_tx = 1;
                  10: m_tx = 0;
                  14: m_im = cmd_word_i[7:0];
                  15: m_rm = cmd_word_i[7:0];
                  default: ;
               endcase
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R13 status", status_o, m_stat);
         chk("R2 window", 16'(window_o), 16'(m_win));
         chk("R7 irq", 16'(irq_o), 16'(|(m_lat & m_im)));
         chk("R10 rx_en", 16'(rx_en_o), 16'(m_rx));
         chk("R10 tx_en", 16'(tx_en_o), 16'(m_tx));
         chk("R11 strobes", {13'd0, rx_rst_o, tx_rst_o, gbl_rst_o}, {13'd0, m_rxs, m_txs, m_gs});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int op, input int arg);
      @(negedge clk);
      cmd_wr_i   = 1'b1;
      cmd_word_i = {5'(op), 11'(arg)};
      @(negedge clk);
      cmd_wr_i   = 1'b0;
   endtask

   task automatic rd_exp(input string tag, input logic [15:0] exp);
      @(negedge clk);
      stat_rd_i = 1'b1;
      @(negedge clk);
      stat_rd_i = 1'b0;
      chk(tag, status_o, exp);
   endtask

   task automatic fin();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc >= 20000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
         fin();
      end
   end

   initial begin
      int busy_seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 R8 reset state
      rd_exp("R8 reset status", 16'h0000);
      chk("R10 reset rx_en", 16'(rx_en_o), 16'd0);
      chk("R10 reset tx_en", 16'(tx_en_o), 16'd0);

      // R2 window select, upper argument bits ignored
      wr(1, 11'h7F5);
      chk("R2 window", 16'(window_o), 16'd5);
      rd_exp("R2 status window", 16'hA000);

      // R1 unknown opcodes have no effect
      wr(2, 11'h7FF); wr(6, 11'h7FF); wr(7, 11'h7FF);
      wr(8, 11'h7FF); wr(16, 11'h7FF); wr(31, 11'h7FF);
      rd_exp("R1 unknown opcodes", 16'hA000);
      chk("R1 window kept", 16'(window_o), 16'd5);
      chk("R1 enables kept", {14'd0, rx_en_o, tx_en_o}, 16'd0);

      // R3 event latches, no summary while mask is clear
      @(negedge clk); ev_tx_done_i = 1'b1;
      @(negedge clk); ev_tx_done_i = 1'b0;
      rd_exp("R3 tx done latched", 16'hA004);
      chk("R7 irq masked", 16'(irq_o), 16'd0);

      // R7 enable mask, R6 summary bit
      wr(14, 8'hFF);
      chk("R7 irq enabled", 16'(irq_o), 16'd1);
      @(negedge clk); ev_rx_done_i = 1'b1;
      @(negedge clk); ev_rx_done_i = 1'b0;
      rd_exp("R6 summary set", 16'hA015);

      // R8 read mask
      wr(15, 8'h10);
      rd_exp("R8 read mask", 16'hA010);
      wr(15, 8'hFF);

      // R4 acknowledge
      wr(13, 8'h15);
      rd_exp("R4 ack clears", 16'hA000);
      chk("R4 irq after ack", 16'(irq_o), 16'd0);

      // R5 software request
      wr(12, 11'h7FF);
      rd_exp("R5 sw request", 16'hA041);
      wr(13, 8'h41);

      // R12 event and ack in the same cycle
      @(negedge clk);
      ev_stats_i = 1'b1; cmd_wr_i = 1'b1; cmd_word_i = {5'd13, 11'h080};
      @(negedge clk);
      ev_stats_i = 1'b0; cmd_wr_i = 1'b0;
      rd_exp("R12 set wins", 16'hA081);
      wr(13, 8'hFF);

      // R10 enables
      wr(4, 0);  chk("R10 rx on",  16'(rx_en_o), 16'd1);
      wr(9, 0);  chk("R10 tx on",  16'(tx_en_o), 16'd1);
      wr(3, 0);  chk("R10 rx off", 16'(rx_en_o), 16'd0);
      wr(10, 0); chk("R10 tx off", 16'(tx_en_o), 16'd0);

      // R11 strobes
      wr(5, 0);
      chk("R11 rx strobe high", 16'(rx_rst_o), 16'd1);
      @(negedge clk);
      chk("R11 rx strobe low", 16'(rx_rst_o), 16'd0);
      wr(11, 0);
      chk("R11 tx strobe high", 16'(tx_rst_o), 16'd1);
      @(negedge clk);
      chk("R11 tx strobe low", 16'(tx_rst_o), 16'd0);

      // R9 global reset: state restored, busy window, writes ignored
      wr(14, 8'hFF); wr(4, 0); wr(1, 2);
      @(negedge clk); cmd_wr_i = 1'b1; cmd_word_i = 16'h0000;
      @(negedge clk); cmd_word_i = {5'd1, 11'd3}; stat_rd_i = 1'b1;
      chk("R11 global strobe", 16'(gbl_rst_o), 16'd1);
      busy_seen = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (i == 0) cmd_wr_i = 1'b0;
         if (status_o[12]) busy_seen++;
      end
      stat_rd_i = 1'b0;
      chk("R9 busy cycles", 16'(busy_seen), 16'(HOLD));
      chk("R9 write ignored while busy", 16'(window_o), 16'd0);
      chk("R9 rx_en cleared", 16'(rx_en_o), 16'd0);
      rd_exp("R9 status after reset", 16'h0000);
      @(negedge clk); ev_tx_done_i = 1'b1;
      @(negedge clk); ev_tx_done_i = 1'b0;
      chk("R9 imask cleared", 16'(irq_o), 16'd0);
      rd_exp("R9 read mask restored", 16'h0004);

      repeat (3) @(negedge clk);
      fin();
   end

endmodule